// File: doc/BRIEF.md
# Sampled Entropy Collection Controller

This block gathers random bits from a single-bit entropy input and holds them in a bank of 32-bit words that software reads over a simple register interface. Software first programs a sample period. It then writes a control word that picks the collection length, the oscillator speed setting and the source enable, and raises a start bit. From then on the controller captures one entropy bit each time the sample period runs out. When the requested number of bits has been captured, hardware drops the start bit, so software polls that bit to learn that the data is ready.

Writes to the control register are merged bit by bit. The upper half of the write data says which bits of the lower half are actually updated. A separate reset-control register cancels a collection in progress and wipes the stored data. The oscillator itself is outside the block: the block drives a speed select and an enable out, and receives one entropy bit in.

Register map (byte offsets; all accesses are full 32-bit words):

| Offset | Register |
|---|---|
| 0x004 | reset control (write bit 0 = 1 to abort and clear) |
| 0x400 | control: bit 0 start, bit 1 enable, bits 3:2 speed, bits 5:4 length, bits 15:6 plain storage |
| 0x404 | sample period in clock cycles |
| 0x410 + 4*n | output word n, n = 0..7 |

Top module: `harvest_top`

## Requirements
- R1: A write to 0x400 updates control bit i (i = 0..15) only when write-data bit 16+i is 1. Bits that are not enabled keep their value. A read of 0x400 returns the 16 control bits in bits 15:0, and bits 31:16 read as 0.
- R2: Setting the start bit (bit 0) while the resulting enable bit (bit 1) is 0 leaves start at 0, and no bit is captured.
- R3: A start written at clock edge E with period P and length code L collects N = 64*(L+1) bits. Bit k (k = 0..N-1) is the entropy input sampled at edge E+(k+1)*P. It lands in output word k/32 at bit position k%32, so word 0 fills first, least significant bit first. Start reads 1 up to edge E+N*P and 0 after it.
- R4: Output words at or above index N/32 keep their previous contents through a collection.
- R5: A sample period of 0 behaves exactly as a period of 1.
- R6: A write to the sample-period register (0x404) while start is 1 is ignored. The register reads back the last value accepted.
- R7: The 2-bit speed output always equals control bits 3:2, and the enable output equals control bit 1.
- R8: Clearing the enable bit during a collection clears start at once, and no further bits are captured.
- R9: Writing 1 to bit 0 of the reset-control register (0x004) clears start, stops capture and sets all output words to 0.
- R10: After reset all registers read 0. Reads of 0x004 and of any unmapped or unaligned offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous active-low reset |
| wrEn | input | 1 | write strobe for the word at `addr` |
| rdEn | input | 1 | read strobe; `rdata` is updated on the same edge |
| addr | input | ADDR_W | byte offset of the access |
| wdata | input | 32 | write data |
| rdata | output | 32 | registered read data |
| entropyBit | input | 1 | raw bit from the entropy source |
| srcEnable | output | 1 | enable to the entropy source |
| oscSpeed | output | 2 | oscillator speed select |

## Verification
The bench builds the block with its default parameters: eight output words, so lengths of 64, 128, 192 and 256 bits, and a 32-bit period register. Periods are kept between 0 and 4, so even a full 256-bit collection ends within about a thousand cycles. The bench can therefore run many random collections and compare every output word bit by bit. Because the periods are short, the exact cycle on which start drops can be checked. Running a short collection after a long one shows whether the upper words are left alone.

// File: rtl/harvest_pkg.sv
package harvest_pkg;
  localparam int CTL_BITS = 16;

  // strobes from the control path to the output store
  typedef struct packed {
    logic clearAll;
    logic capture;
    logic newBit;
  } harvStrobe_t;
endpackage

// File: rtl/harvest_ctrl.sv
module harvest_ctrl
  import harvest_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int IDX_W     = 8,
  parameter int STEP_BITS = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctlWr,
  input  logic                scWr,
  input  logic                rcWr,
  input  logic [31:0]         wdata,
  input  logic                entropyBit,
  output logic [CTL_BITS-1:0] ctlBits,
  output logic [CNT_W-1:0]    sampleCnt,
  output harvStrobe_t         strobe,
  output logic [IDX_W-1:0]    bitIdx
);
  logic [CTL_BITS-1:0] ctlQ;
  logic [CNT_W-1:0]    scQ, perCnt, effPer;
  logic [IDX_W-1:0]    bitCnt, lastIdx;
  logic [CTL_BITS-1:0] mask, merged;
  logic running, tick, finishNow, startReq, abortReq, newEn;

  assign running   = ctlQ[0];
  assign effPer    = (scQ == '0) ? CNT_W'(1) : scQ;
  assign tick      = running && (perCnt == effPer - CNT_W'(1));
  assign finishNow = tick && (bitCnt == lastIdx);

  assign mask      = wdata[31:16];
  assign merged    = (ctlQ & ~mask) | (wdata[15:0] & mask);
  assign newEn     = merged[1];
  assign startReq  = ctlWr && !running && merged[0] && newEn;
  assign abortReq  = rcWr && wdata[0];

  // control word, start bit set by software and cleared by hardware
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ <= '0;
    end else if (abortReq) begin
      ctlQ[0] <= 1'b0;
    end else if (ctlWr) begin
      if (running) ctlQ <= {merged[CTL_BITS-1:1], newEn & ~finishNow};
      else         ctlQ <= {merged[CTL_BITS-1:1], merged[0] & newEn};
    end else if (finishNow) begin
      ctlQ[0] <= 1'b0;
    end
  end

  // sample period register, frozen while collecting
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 scQ <= '0;
    else if (scWr && !running) scQ <= wdata[CNT_W-1:0];
  end

  // period and bit counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perCnt  <= '0;
      bitCnt  <= '0;
      lastIdx <= '0;
    end else if (abortReq || startReq) begin
      perCnt <= '0;
      bitCnt <= '0;
      if (startReq)
        lastIdx <= IDX_W'((int'(merged[5:4]) + 1) * STEP_BITS - 1);
    end else if (running) begin
      if (tick) begin
        perCnt <= '0;
        bitCnt <= bitCnt + IDX_W'(1);
      end else begin
        perCnt <= perCnt + CNT_W'(1);
      end
    end
  end

  assign strobe.clearAll = abortReq;
  assign strobe.capture  = tick;
  assign strobe.newBit   = entropyBit;
  assign bitIdx          = bitCnt;
  assign ctlBits         = ctlQ;
  assign sampleCnt       = scQ;
endmodule

// File: rtl/harvest_store.sv
module harvest_store
  import harvest_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int IDX_W     = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  harvStrobe_t               strobe,
  input  logic [IDX_W-1:0]          bitIdx,
  output logic [NUM_WORDS*32-1:0]   wordsFlat
);
  localparam int SEL_W = IDX_W - 5;

  logic [SEL_W-1:0] wordSel;
  logic [4:0]       bitSel;

  assign wordSel = bitIdx[IDX_W-1:5];
  assign bitSel  = bitIdx[4:0];

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] wordQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        wordQ <= '0;
      else if (strobe.clearAll)
        wordQ <= '0;
      else if (strobe.capture && (wordSel == SEL_W'(w)))
        wordQ[bitSel] <= strobe.newBit;
    end
    assign wordsFlat[w*32 +: 32] = wordQ;
  end
endmodule

// File: rtl/harvest_top.sv
module harvest_top
  import harvest_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          CNT_W     = 32,
  parameter int          NUM_WORDS = 8,
  parameter logic [11:0] RC_OFF    = 12'h004,
  parameter logic [11:0] CTL_OFF   = 12'h400,
  parameter logic [11:0] SC_OFF    = 12'h404,
  parameter logic [11:0] OUT_BASE  = 12'h410
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              entropyBit,
  output logic              srcEnable,
  output logic [1:0]        oscSpeed
);
  localparam int TOTAL_BITS = NUM_WORDS * 32;
  localparam int IDX_W      = $clog2(TOTAL_BITS);
  localparam int STEP_BITS  = TOTAL_BITS / 4;

  logic [CTL_BITS-1:0]      ctlBits;
  logic [CNT_W-1:0]         sampleCnt;
  harvStrobe_t              strobe;
  logic [IDX_W-1:0]         bitIdx;
  logic [TOTAL_BITS-1:0]    wordsFlat;
  logic                     ctlWr, scWr, rcWr;
  logic [31:0]              rdNext;

  assign ctlWr = wrEn && (addr == ADDR_W'(CTL_OFF));
  assign scWr  = wrEn && (addr == ADDR_W'(SC_OFF));
  assign rcWr  = wrEn && (addr == ADDR_W'(RC_OFF));

  harvest_ctrl #(.CNT_W(CNT_W), .IDX_W(IDX_W), .STEP_BITS(STEP_BITS)) ctrlI (
    .clk(clk), .rstN(rstN), .ctlWr(ctlWr), .scWr(scWr), .rcWr(rcWr),
    .wdata(wdata), .entropyBit(entropyBit), .ctlBits(ctlBits),
    .sampleCnt(sampleCnt), .strobe(strobe), .bitIdx(bitIdx)
  );

  harvest_store #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) storeI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx),
    .wordsFlat(wordsFlat)
  );

  always_comb begin
    rdNext = '0;
    if (addr == ADDR_W'(CTL_OFF)) rdNext = 32'(ctlBits);
    if (addr == ADDR_W'(SC_OFF))  rdNext = 32'(sampleCnt);
    for (int w = 0; w < NUM_WORDS; w++) begin
      if (addr == ADDR_W'(int'(OUT_BASE) + 4 * w))
        rdNext = wordsFlat[w*32 +: 32];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdata <= '0;
    else if (rdEn) rdata <= rdNext;
  end

  assign srcEnable = ctlBits[1];
  assign oscSpeed  = ctlBits[3:2];
endmodule

// File: rtl/harvest_chk.sv
module harvest_chk #(
  parameter int          ADDR_W  = 12,
  parameter int          CNT_W   = 32,
  parameter logic [11:0] RC_OFF  = 12'h004,
  parameter logic [11:0] CTL_OFF = 12'h400,
  parameter logic [11:0] SC_OFF  = 12'h404
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [15:0]       ctlBits,
  input logic [CNT_W-1:0]  sampleCnt
);
  // R2
  start_needs_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctlBits[0] |-> ctlBits[1]);

  // R9
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(RC_OFF) && wdata[0]) |=> !ctlBits[0]);

  // R6
  period_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(SC_OFF) && ctlBits[0]) |=> $stable(sampleCnt));

  // R1
  ctl_high_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(CTL_OFF)) |=> (rdata[31:16] == 16'h0));

  // R1
  masked_none_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == ADDR_W'(CTL_OFF) && wdata[31:16] == 16'h0)
      |=> (ctlBits[15:1] == $past(ctlBits[15:1])));

  // R10
  rc_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_W'(RC_OFF)) |=> (rdata == 32'h0));
endmodule

bind harvest_top harvest_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RC_OFF(RC_OFF), .CTL_OFF(CTL_OFF), .SC_OFF(SC_OFF)
) chkI (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wdata(wdata),
  .rdata(rdata), .ctlBits(ctlBits), .sampleCnt(sampleCnt)
);

// File: tb/harvest_top_test.sv
module harvest_top_test;
  localparam logic [11:0] A_RC  = 12'h004;
  localparam logic [11:0] A_CTL = 12'h400;
  localparam logic [11:0] A_SC  = 12'h404;
  localparam logic [11:0] A_OUT = 12'h410;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        entropyBit = 1'b0;
  logic        srcEnable;
  logic [1:0]  oscSpeed;

  int          nChecks = 0, nFails = 0;
  int          edgeCnt = 0;
  logic [31:0] patSeed = 32'h1234_5678;
  logic [31:0] expW [8];

  harvest_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .entropyBit(entropyBit),
    .srcEnable(srcEnable), .oscSpeed(oscSpeed)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  function automatic logic patBit(int n);
    logic [31:0] h;
    h = (32'(n) * 32'h9E37_79B1) ^ patSeed;
    return h[17] ^ h[29];
  endfunction

  // entropy value seen at edge n+1 is patBit(n)
  always @(negedge clk) entropyBit <= patBit(edgeCnt);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // all bus tasks start and end at a negedge
  task automatic wr(logic [11:0] a, logic [31:0] d, output int e);
    wrEn = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 e = edgeCnt;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); v = rdata; rdEn = 1'b0;
  endtask

  task automatic rdAt(int r, logic [11:0] a, output logic [31:0] v);
    while (edgeCnt < r - 1) @(negedge clk);
    rd(a, v);
  endtask

  task automatic checkWords(string req);
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(A_OUT + 12'(4 * w), v);
      check(req, v, expW[w]);
    end
  endtask

  task automatic doRun(int len, int per, int spd);
    int e0, d, n, ep;
    logic [31:0] v;
    wr(A_SC, 32'(per), e0);
    wr(A_CTL, {16'h003F, 10'h0, 2'(len), 2'(spd), 2'b11}, e0);
    n  = 64 * (len + 1);
    ep = (per == 0) ? 1 : per;
    for (int k = 0; k < n; k++) expW[k / 32][k % 32] = patBit(e0 + (k + 1) * ep - 1);
    check("R7 speed", 32'(oscSpeed), 32'(spd));
    check("R7 enable", 32'(srcEnable), 32'd1);
    d = e0 + n * ep;
    rdAt(d, A_CTL, v);
    check("R3 start held", v, {26'h0, 2'(len), 2'(spd), 2'b11});
    rd(A_CTL, v);
    check("R3 start cleared", v, {26'h0, 2'(len), 2'(spd), 2'b10});
    checkWords(per == 0 ? "R5 words" : "R3/R4 words");
  endtask

  initial begin
    int e, e0;
    logic [31:0] v, v1;
    void'($urandom(32'd2718));
    for (int w = 0; w < 8; w++) expW[w] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10 reset state and unmapped reads
    rd(A_CTL, v); check("R10 ctl reset", v, 32'h0);
    rd(A_SC, v);  check("R10 period reset", v, 32'h0);
    checkWords("R10 words reset");
    rd(12'h408, v); check("R10 unmapped", v, 32'h0);
    rd(12'h411, v); check("R10 unaligned", v, 32'h0);
    rd(12'h430, v); check("R10 past words", v, 32'h0);
    rd(A_RC, v);    check("R10 reset-ctl read", v, 32'h0);

    // R1 masked writes, R7 speed output
    wr(A_CTL, 32'h000C_000C, e);
    rd(A_CTL, v); check("R1 speed only", v, 32'h0000_000C);
    check("R7 speed port", 32'(oscSpeed), 32'd3);
    wr(A_CTL, 32'h0000_FFFF, e);
    rd(A_CTL, v); check("R1 no enables", v, 32'h0000_000C);
    wr(A_CTL, 32'hFFC0_AB00, e);
    rd(A_CTL, v); check("R1 upper bits", v, 32'h0000_AB0C);

    // R2 start without enable
    wr(A_CTL, 32'h0003_0001, e);
    rd(A_CTL, v); check("R2 start stays 0", v, 32'h0000_AB0C);
    repeat (80) @(negedge clk);
    rd(A_OUT, v); check("R2 no capture", v, 32'h0);
    wr(A_CTL, 32'hFFFF_0000, e);

    // R3/R4 directed: long then short collection
    doRun(3, 1, 0);
    doRun(0, 2, 1);
    doRun(1, 0, 2);

    // R6 period write during a run is ignored
    wr(A_SC, 32'd2, e);
    wr(A_CTL, 32'h003F_0003, e0);
    for (int k = 0; k < 64; k++) expW[k / 32][k % 32] = patBit(e0 + (k + 1) * 2 - 1);
    wr(A_SC, 32'd7, e);
    rdAt(e0 + 128, A_CTL, v); check("R6 old period timing", 32'(v[0]), 32'd1);
    rd(A_CTL, v);             check("R6 done on old period", 32'(v[0]), 32'd0);
    rd(A_SC, v);              check("R6 period unchanged", v, 32'd2);
    checkWords("R6 words");
    wr(A_SC, 32'd3, e);
    rd(A_SC, v);              check("R6 period accepted idle", v, 32'd3);

    // random collections
    for (int i = 0; i < 8; i++) begin
      patSeed = $urandom;
      doRun(int'($urandom % 4), int'($urandom % 5), int'($urandom % 4));
    end

    // R8 enable dropped mid-run
    wr(A_SC, 32'd1, e);
    wr(A_CTL, 32'h003F_0033, e0);
    repeat (20) @(negedge clk);
    wr(A_CTL, 32'h0002_0000, e);
    rd(A_CTL, v);  check("R8 start cleared", 32'(v[1:0]), 32'd0);
    rd(A_OUT + 12'd4, v1);
    repeat (100) @(negedge clk);
    rd(A_OUT + 12'd4, v); check("R8 no more capture", v, v1);

    // R9 reset control clears words
    wr(A_RC, 32'h1, e);
    for (int w = 0; w < 8; w++) expW[w] = '0;
    checkWords("R9 clear idle");

    // R9 abort during a run
    patSeed = 32'hDEAD_BEEF;
    wr(A_CTL, 32'h003F_0033, e0);
    repeat (40) @(negedge clk);
    wr(A_RC, 32'h1, e);
    rd(A_CTL, v); check("R9 start cleared", 32'(v[0]), 32'd0);
    repeat (300) @(negedge clk);
    checkWords("R9 abort words");

    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule